// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver

This block receives asynchronous serial frames of one start bit, eight data bits and one stop bit, at a bit rate fixed when the block is built. A phase accumulator turns the system clock into an enable pulse at sixteen times the bit rate. All receive timing runs from that pulse. The input is first synchronised to the clock. It can then pass through a small majority filter built from a saturating two-bit up/down counter. The filter removes disturbances that last only one sample.

The framer hunts for a low level. It restarts its half-bit count every time the line reads high, so a frame begins only when the line has stayed low up to the middle of the start bit. From that point the framer takes one sample every sixteen ticks: eight data bits, least significant bit first, and then the stop bit. It hands the byte over at the middle of the stop bit and starts hunting again at once. The byte lands in a holding register and raises a ready flag, and an interrupt line follows that flag. Software drops both with a one-cycle clear pulse. A low stop sample marks a framing error. A byte that lands while the flag is still set marks an overrun.

Top module: `srx_receiver`

## Requirements
- R1: The tick generator adds 16*BAUD to an accumulator every clock and subtracts CLK_HZ when the sum reaches CLK_HZ, issuing one tick each time. When the clock-to-tick ratio is not an integer, frames must still be received correctly.
- R2: A frame starts only after the filtered line has read low on 8 consecutive ticks. Any high reading restarts that count, so a low pulse shorter than half a bit never produces a byte.
- R3: After the start-bit centre, the framer takes 8 data samples 16 ticks apart. The first sample becomes bit 0 of `rx_byte` and the last becomes bit 7. Every 8-bit value is received unchanged.
- R4: Start hunting resumes at the stop-bit sample, so a frame whose start bit directly follows the previous stop bit is received correctly.
- R5: A byte whose bit 7 is 0, followed by an idle line, yields exactly one byte and no further delivery.
- R6: With FILTER_EN=1, an inverted disturbance of one tick is ignored, both on the idle line and inside a data bit.
- R7: `ready` and `irq` go to 1 when a byte is delivered, which happens at the stop-bit sample and not before the stop bit starts. `rx_byte` changes only at delivery.
- R8: A one-cycle `clear_ready` pulse makes `ready`, `irq` and `overrun` read 0 on the following cycle and leaves `rx_byte` unchanged.
- R9: `frame_err` takes the inverse of the stop sample of the most recent byte: 1 for a low stop bit, 0 for a high one.
- R10: A delivery while `ready` is still 1 replaces `rx_byte` with the newer byte and sets `overrun` to 1.
- R11: After reset, `ready`, `irq`, `frame_err`, `overrun` and `rx_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| clear_ready | input | 1 | One-cycle pulse that clears the ready and overrun flags |
| rx_byte | output | DATA_W | Holding register with the last received byte |
| ready | output | 1 | A byte is waiting |
| irq | output | 1 | Interrupt request, high while a byte is waiting |
| frame_err | output | 1 | The last byte had a low stop sample |
| overrun | output | 1 | A byte was overwritten before it was cleared |

## Verification
The hardest condition to reach from the ports is a start bit that follows the previous stop bit with no idle time. Detection has to rearm at the stop-bit sample, or the next start edge is seen late and every following sample drifts toward a bit edge. The bench reaches this by chaining frames without any gap, at a clock-to-tick ratio of about 2.08. At that ratio the tick phase moves from frame to frame. The bench also places one-tick glitches and sub-half-bit low pulses on an otherwise clean line. Those cases exercise the filter and the start qualification separately from normal reception.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_DATA = 2'd1,
        S_STOP = 2'd2
    } srx_state_e;
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned BAUD   = 115_200,
    parameter int unsigned OVS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned INC   = BAUD * OVS;
    localparam int unsigned ACC_W = $clog2(CLK_HZ + INC) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } tg_t;

    tg_t tg_d, tg_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        tg_d = tg_q;
        sum  = tg_q.acc + ACC_W'(INC);
        if (sum >= ACC_W'(CLK_HZ)) begin
            tg_d.acc  = sum - ACC_W'(CLK_HZ);
            tg_d.tick = 1'b1;
        end else begin
            tg_d.acc  = sum;
            tg_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign tick = tg_q.tick;

    generate
        if (CLK_HZ >= 2 * INC) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end
    endgenerate
endmodule

// File: rtl/srx_glitch_filt.sv
module srx_glitch_filt #(
    parameter bit FILTER_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic clean
);
    typedef struct packed {
        logic [1:0] sync;
        logic [1:0] cnt;
    } gf_t;

    gf_t gf_d, gf_q;

    always_comb begin
        gf_d      = gf_q;
        gf_d.sync = {gf_q.sync[0], raw};
        if (FILTER_EN && tick) begin
            if (gf_q.sync[1] && gf_q.cnt != 2'd3)
                gf_d.cnt = gf_q.cnt + 2'd1;
            else if (!gf_q.sync[1] && gf_q.cnt != 2'd0)
                gf_d.cnt = gf_q.cnt - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gf_q <= '{sync: 2'b11, cnt: 2'd3};
        else        gf_q <= gf_d;
    end

    generate
        if (FILTER_EN) begin : g_vote
            assign clean = gf_q.cnt[1];
            AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(clean) |-> $past(tick)); // R6
        end else begin : g_pass
            assign clean = gf_q.sync[1];
        end
    endgenerate
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bit_in,
    input  logic              clear,
    output logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              ferr,
    output logic              ovr
);
    localparam int unsigned TW   = $clog2(OVS);
    localparam int unsigned BW   = $clog2(DATA_W);
    localparam int unsigned HALF = OVS / 2 - 1;
    localparam int unsigned LAST = OVS - 1;

    typedef struct packed {
        srx_state_e        state;
        logic [TW-1:0]     tcnt;
        logic [BW-1:0]     bcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] hold;
        logic              ready;
        logic              ferr;
        logic              ovr;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (clear) begin
            fr_d.ready = 1'b0;
            fr_d.ovr   = 1'b0;
        end
        if (tick) begin
            case (fr_q.state)
                S_HUNT: begin
                    if (bit_in)
                        fr_d.tcnt = TW'(HALF);
                    else if (fr_q.tcnt == '0) begin
                        fr_d.state = S_DATA;
                        fr_d.tcnt  = TW'(LAST);
                        fr_d.bcnt  = '0;
                    end else
                        fr_d.tcnt = fr_q.tcnt - 1'b1;
                end
                S_DATA: begin
                    if (fr_q.tcnt == '0) begin
                        fr_d.shreg = {bit_in, fr_q.shreg[DATA_W-1:1]};
                        fr_d.tcnt  = TW'(LAST);
                        if (fr_q.bcnt == BW'(DATA_W - 1))
                            fr_d.state = S_STOP;
                        else
                            fr_d.bcnt = fr_q.bcnt + 1'b1;
                    end else
                        fr_d.tcnt = fr_q.tcnt - 1'b1;
                end
                S_STOP: begin
                    if (fr_q.tcnt == '0) begin
                        fr_d.hold  = fr_q.shreg;
                        fr_d.ready = 1'b1;
                        fr_d.ferr  = !bit_in;
                        if (fr_q.ready && !clear)
                            fr_d.ovr = 1'b1;
                        fr_d.state = S_HUNT;
                        fr_d.tcnt  = TW'(HALF);
                    end else
                        fr_d.tcnt = fr_q.tcnt - 1'b1;
                end
                default: begin
                    fr_d.state = S_HUNT;
                    fr_d.tcnt  = TW'(HALF);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q       <= '0;
            fr_q.state <= S_HUNT;
            fr_q.tcnt  <= TW'(HALF);
        end else begin
            fr_q <= fr_d;
        end
    end

    assign data  = fr_q.hold;
    assign ready = fr_q.ready;
    assign ferr  = fr_q.ferr;
    assign ovr   = fr_q.ovr;

    AST_START_WAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.state == S_DATA && $past(fr_q.state) == S_HUNT) |-> !$past(bit_in)); // R2
    AST_READY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.ready) |-> $past(fr_q.state) == S_STOP); // R7
    AST_HOLD_ON_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fr_q.hold) |-> fr_q.ready); // R7
    AST_CLEAR_DROPS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !fr_q.ovr); // R8
    AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_q.ovr) |-> $past(fr_q.ready)); // R10
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BAUD      = 115_200,
    parameter int unsigned OVS       = 16,
    parameter int unsigned DATA_W    = 8,
    parameter bit          FILTER_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              clear_ready,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ready,
    output logic              irq,
    output logic              frame_err,
    output logic              overrun
);
    logic tick;
    logic clean;

    srx_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    srx_glitch_filt #(.FILTER_EN(FILTER_EN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .raw   (rxd),
        .clean (clean)
    );

    srx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_frm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .bit_in (clean),
        .clear  (clear_ready),
        .data   (rx_byte),
        .ready  (ready),
        .ferr   (frame_err),
        .ovr    (overrun)
    );

    assign irq = ready;
endmodule

// File: tb/sim_srx_receiver.sv
`timescale 1ns/1ps
module sim_srx_receiver;
    localparam real BIT_NS = 1.0e9 / 1500000.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       clear_ready = 1'b0;
    logic [7:0] rx_byte;
    logic       ready, irq, frame_err, overrun;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    srx_receiver #(.CLK_HZ(50_000_000), .BAUD(1_500_000), .OVS(16),
                   .DATA_W(8), .FILTER_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .clear_ready(clear_ready),
        .rx_byte(rx_byte), .ready(ready), .irq(irq),
        .frame_err(frame_err), .overrun(overrun)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_bit, input bit probe,
                              input int glitch_bit);
        rxd = 1'b0;
        #(BIT_NS);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            if (i == glitch_bit) begin
                #(BIT_NS / 2.0 - 20.0);
                rxd = ~b[i];
                #40.0;
                rxd = b[i];
                #(BIT_NS / 2.0 - 20.0);
            end else begin
                #(BIT_NS);
            end
        end
        rxd = stop_bit;
        if (probe) begin
            #(BIT_NS / 4.0);
            check("R7 no delivery before stop bit", 32'(ready), 32'd0);
            #(BIT_NS * 0.75);
        end else begin
            #(BIT_NS);
        end
        rxd = 1'b1;
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        clear_ready = 1'b1;
        @(negedge clk);
        clear_ready = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R11 ready reset", 32'(ready), 32'd0);
        check("R11 irq reset", 32'(irq), 32'd0);
        check("R11 frame_err reset", 32'(frame_err), 32'd0);
        check("R11 overrun reset", 32'(overrun), 32'd0);
        check("R11 rx_byte reset", 32'(rx_byte), 32'd0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // R1 R3 R7 R8: every byte value at a fractional tick ratio
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b1, 1'b1, -1);
            repeat (8) @(negedge clk);
            check("R3 byte value", 32'(rx_byte), 32'(b));
            check("R1 byte received", 32'(ready), 32'd1);
            check("R7 irq with ready", 32'(irq), 32'd1);
            check("R9 good stop", 32'(frame_err), 32'd0);
            check("R10 no overrun", 32'(overrun), 32'd0);
            @(negedge clk);
            clear_ready = 1'b1;
            @(negedge clk);
            clear_ready = 1'b0;
            check("R8 ready cleared", 32'(ready), 32'd0);
            check("R8 irq cleared", 32'(irq), 32'd0);
            check("R8 byte kept", 32'(rx_byte), 32'(b));
        end

        // R5: bit 7 low then idle gives one byte only
        send_frame(8'h7F, 1'b1, 1'b0, -1);
        repeat (8) @(negedge clk);
        check("R5 byte 7F", 32'(rx_byte), 32'h7F);
        clear_pulse();
        repeat (700) @(negedge clk);
        check("R5 no extra byte", 32'(ready), 32'd0);

        // R6: one-tick glitch on idle line
        @(negedge clk);
        rxd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rxd = 1'b1;
        repeat (700) @(negedge clk);
        check("R6 idle glitch ignored", 32'(ready), 32'd0);

        // R2: low shorter than half a bit
        rxd = 1'b0;
        #(BIT_NS * 0.4);
        rxd = 1'b1;
        repeat (700) @(negedge clk);
        check("R2 short low ignored", 32'(ready), 32'd0);

        // R6: glitch inside data bit 3
        send_frame(8'h96, 1'b1, 1'b0, 3);
        repeat (8) @(negedge clk);
        check("R6 data glitch ignored", 32'(rx_byte), 32'h96);
        check("R6 byte ready", 32'(ready), 32'd1);
        clear_pulse();

        // R9: low stop sample
        repeat (20) @(negedge clk);
        send_frame(8'hA5, 1'b0, 1'b0, -1);
        repeat (8) @(negedge clk);
        check("R9 framing flagged", 32'(frame_err), 32'd1);
        check("R9 byte delivered", 32'(rx_byte), 32'hA5);
        check("R9 ready", 32'(ready), 32'd1);
        clear_pulse();
        repeat (700) @(negedge clk);
        clear_pulse();
        repeat (20) @(negedge clk);
        send_frame(8'h5C, 1'b1, 1'b0, -1);
        repeat (8) @(negedge clk);
        check("R9 good frame clears flag", 32'(frame_err), 32'd0);
        check("R9 good frame data", 32'(rx_byte), 32'h5C);
        clear_pulse();

        // R4 R10: three frames back to back, no clear in between
        repeat (20) @(negedge clk);
        send_frame(8'h3C, 1'b1, 1'b0, -1);
        send_frame(8'hC3, 1'b1, 1'b0, -1);
        send_frame(8'h5A, 1'b1, 1'b0, -1);
        repeat (8) @(negedge clk);
        check("R4 chained frame data", 32'(rx_byte), 32'h5A);
        check("R10 overrun set", 32'(overrun), 32'd1);
        check("R4 chained stop good", 32'(frame_err), 32'd0);
        @(negedge clk);
        clear_ready = 1'b1;
        @(negedge clk);
        clear_ready = 1'b0;
        check("R8 overrun cleared", 32'(overrun), 32'd0);
        check("R8 ready cleared after overrun", 32'(ready), 32'd0);

        // R8: clear with nothing pending
        clear_pulse();
        check("R8 idle clear keeps byte", 32'(rx_byte), 32'h5A);
        check("R8 idle clear ready", 32'(ready), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule